// File: doc/BRIEF.md
# Dual-Issue Stall and Squash Controller

This block decides, every cycle, how the instruction pair in decode of a two-wide, in-order, five-stage pipeline moves into execute. The two issue slots are tied to address parity: the even word always travels in slot 0 and the odd word in slot 1. From the opcode class, source registers and destination register of each decode instruction, and the class, validity and destination of each execute instruction, it produces a decode hold and a per-slot no-op injection into execute. When a pair has to be split, it remembers which half has already left, so that on the replay pass that half is presented as a no-op.

It also handles two more cases. When a taken transfer lands on an odd word, the even word fetched with the target is dropped. At writeback, when both slots name the same destination register, the even slot's write enable is withdrawn. A destination of register 0 means the instruction writes nothing.

Top module: `dual_issue_hazard`

## Requirements
- R1: A branch, jump or JAL (class codes 3, 4, 5) valid in execute slot 0 turns both decode instructions into no-ops (`ex_nop0`=`ex_nop1`=1) without a hold. This takes priority over every other case.
- R2: A branch, jump or JAL valid in execute slot 1 always turns decode slot 1 into a no-op, while the even decode instruction (the delay slot) proceeds. If that even instruction must also stall under R3, the pair is held and the odd instruction stays dead on the next pass.
- R3: When the even decode instruction reads (rs or rt) the nonzero destination of a valid load (code 1) or JAL (code 5) in either execute slot, the pair is held for one cycle and both execute slots get no-ops.
- R4: When only the odd decode instruction reads such a result, the even instruction proceeds, the pair is held and the odd slot gets a no-op. On the next cycle the even slot is presented as a no-op and the odd one goes on, unless it still has a hazard.
- R5: When both decode instructions are memory accesses (load code 1 or store code 2), the even one issues first and the odd one follows one cycle later, as in R4.
- R6: When the odd decode instruction reads the nonzero destination of the even decode instruction, the pair is split as in R4.
- R7: After a cycle with `redirect_odd` high, the next pair accepted into decode has its even slot forced to a no-op. If decode is holding, the squash waits for that new pair.
- R8: If both writeback slots have write enable high with equal destinations, `wb0_we_ok` is 0; otherwise it equals `wb0_we`.
- R9: A match on register 0 is never a dependency, and an invalid or already-consumed decode slot creates no hazard.
- R10: A synchronous reset clears all replay and pending-squash state, so the first pair after reset issues with no masked slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d0_valid | input | 1 | Even decode instruction present |
| d0_cls | input | 3 | Even decode class: 0 other, 1 load, 2 store, 3 branch, 4 jump, 5 JAL |
| d0_rs | input | REG_W | Even decode first source |
| d0_rt | input | REG_W | Even decode second source |
| d0_dst | input | REG_W | Even decode destination (0 = none) |
| d1_valid | input | 1 | Odd decode instruction present |
| d1_cls | input | 3 | Odd decode class |
| d1_rs | input | REG_W | Odd decode first source |
| d1_rt | input | REG_W | Odd decode second source |
| x0_valid | input | 1 | Even execute instruction present |
| x0_cls | input | 3 | Even execute class |
| x0_dst | input | REG_W | Even execute destination |
| x1_valid | input | 1 | Odd execute instruction present |
| x1_cls | input | 3 | Odd execute class |
| x1_dst | input | REG_W | Odd execute destination |
| redirect_odd | input | 1 | Taken transfer this cycle targets an odd word |
| wb0_we | input | 1 | Even writeback write enable |
| wb0_dst | input | REG_W | Even writeback destination |
| wb1_we | input | 1 | Odd writeback write enable |
| wb1_dst | input | REG_W | Odd writeback destination |
| dec_hold | output | 1 | Keep the decode pair and stall fetch |
| ex_nop0 | output | 1 | Execute slot 0 receives a no-op |
| ex_nop1 | output | 1 | Execute slot 1 receives a no-op |
| wb0_we_ok | output | 1 | Even writeback enable after odd-wins arbitration |

## Verification
The main sweep crosses every execute class in both slots with every decode class in both slots, plus an absent even instruction. It pairs them with source choices that hit the even execute destination, the odd execute destination, the even decode destination or nothing. This separates the slot-position rules (which execute slot holds the transfer, which decode slot carries the dependency) from the class rules (load or JAL against store or other). Alternating the even execute destination between a real register and register 0 shows that zero matches are ignored. The cycle after each vector checks the replayed pair, which exposes wrong or missing mask state. Directed sequences cover reset clearing a live replay mask, the odd-target squash with and without an intervening hold, and writeback collisions.

// File: rtl/dih_pkg.sv
package dih_pkg;

    typedef enum logic [2:0] {
        OPC_OTHER  = 3'd0,
        OPC_LOAD   = 3'd1,
        OPC_STORE  = 3'd2,
        OPC_BRANCH = 3'd3,
        OPC_JUMP   = 3'd4,
        OPC_JAL    = 3'd5
    } opcls_e;

    typedef struct packed {
        logic ctl_even;   // transfer in execute slot 0
        logic ctl_odd;    // transfer in execute slot 1
        logic late_even;  // even decode needs a late result
        logic late_odd;   // odd decode needs a late result
        logic mem_pair;   // both decode slots touch data memory
        logic pair_dep;   // odd decode reads even decode result
    } hazard_t;

    typedef struct packed {
        logic hold;
        logic nop0;
        logic nop1;
        logic eat0;       // even slot consumed, mask on replay
        logic eat1;       // odd slot dead, mask on replay
    } issue_t;

    function automatic logic is_ctl(input opcls_e c);
        return (c == OPC_BRANCH) || (c == OPC_JUMP) || (c == OPC_JAL);
    endfunction

    function automatic logic is_mem(input opcls_e c);
        return (c == OPC_LOAD) || (c == OPC_STORE);
    endfunction

    function automatic logic is_late(input opcls_e c);
        return (c == OPC_LOAD) || (c == OPC_JAL);
    endfunction

endpackage

// File: rtl/dih_detect.sv
module dih_detect
    import dih_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [1:0]            eff,
    input  logic [1:0][2:0]       dcls,
    input  logic [1:0][REG_W-1:0] dsa,
    input  logic [1:0][REG_W-1:0] dsb,
    input  logic [REG_W-1:0]      even_dst,
    input  logic [1:0]            xv,
    input  logic [1:0][2:0]       xcls,
    input  logic [1:0][REG_W-1:0] xdst,
    output hazard_t               hz
);
    localparam int NSLOT = 2;

    function automatic logic reads(input logic [REG_W-1:0] a,
                                   input logic [REG_W-1:0] b,
                                   input logic [REG_W-1:0] w);
        return (w != '0) && ((a == w) || (b == w));
    endfunction

    logic [NSLOT-1:0] late_src;
    logic [NSLOT-1:0] ctl_src;
    logic [NSLOT-1:0] needs_late;

    for (genvar k = 0; k < NSLOT; k++) begin : g_exec
        assign late_src[k] = xv[k] & is_late(opcls_e'(xcls[k])) & (xdst[k] != '0);
        assign ctl_src[k]  = xv[k] & is_ctl(opcls_e'(xcls[k]));
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_dec
        assign needs_late[s] = eff[s] &
            ((late_src[0] & reads(dsa[s], dsb[s], xdst[0])) |
             (late_src[1] & reads(dsa[s], dsb[s], xdst[1])));
    end

    always_comb begin
        hz.ctl_even  = ctl_src[0];
        hz.ctl_odd   = ctl_src[1];
        hz.late_even = needs_late[0];
        hz.late_odd  = needs_late[1];
        hz.mem_pair  = eff[0] & eff[1] &
                       is_mem(opcls_e'(dcls[0])) & is_mem(opcls_e'(dcls[1]));
        hz.pair_dep  = eff[0] & eff[1] & reads(dsa[1], dsb[1], even_dst);
    end

endmodule

// File: rtl/dih_ctrl.sv
module dih_ctrl
    import dih_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] dec_v,
    input  hazard_t    hz,
    input  logic       redirect_odd,
    output logic [1:0] eff,
    output issue_t     iss
);
    logic mask0_q, mask1_q, pend_q;

    assign eff = dec_v & ~{mask1_q, mask0_q};

    always_comb begin
        iss = '0;
        if (hz.ctl_even) begin
            iss.nop0 = 1'b1;
            iss.nop1 = 1'b1;
        end else if (hz.ctl_odd) begin
            iss.nop1 = 1'b1;
            if (hz.late_even) begin
                iss.hold = 1'b1;
                iss.nop0 = 1'b1;
                iss.eat1 = 1'b1;
            end else begin
                iss.nop0 = ~eff[0];
            end
        end else if (hz.late_even) begin
            iss.hold = 1'b1;
            iss.nop0 = 1'b1;
            iss.nop1 = 1'b1;
        end else if (hz.late_odd | hz.mem_pair | hz.pair_dep) begin
            iss.hold = 1'b1;
            iss.nop1 = 1'b1;
            iss.nop0 = ~eff[0];
            iss.eat0 = eff[0];
        end else begin
            iss.nop0 = ~eff[0];
            iss.nop1 = ~eff[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask0_q <= 1'b0;
            mask1_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (iss.hold) begin
            mask0_q <= mask0_q | iss.eat0;
            mask1_q <= mask1_q | iss.eat1;
            pend_q  <= pend_q | redirect_odd;
        end else begin
            mask0_q <= pend_q | redirect_odd;
            mask1_q <= 1'b0;
            pend_q  <= 1'b0;
        end
    end

    AST_REPLAY_EVEN_NOP: assert property (@(posedge clk) disable iff (rst)
        (iss.hold && !iss.nop0) |=> iss.nop0); // R4

    AST_ODD_TARGET_SQUASH: assert property (@(posedge clk) disable iff (rst)
        (redirect_odd && !iss.hold) |=> iss.nop0); // R7

    AST_HELD_ODD_STAYS: assert property (@(posedge clk) disable iff (rst)
        iss.hold |-> iss.nop1); // R4

endmodule

// File: rtl/dih_waw.sv
module dih_waw #(
    parameter int REG_W = 5
) (
    input  logic             we0,
    input  logic [REG_W-1:0] dst0,
    input  logic             we1,
    input  logic [REG_W-1:0] dst1,
    output logic             we0_ok
);
    logic clash;

    assign clash  = we1 & (dst0 == dst1);
    assign we0_ok = we0 & ~clash;

    always_comb begin
        AST_ODD_WRITE_WINS: assert (!(we0_ok && we1 && (dst0 == dst1))); // R8
    end

endmodule

// File: rtl/dual_issue_hazard.sv
module dual_issue_hazard
    import dih_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             d0_valid,
    input  logic [2:0]       d0_cls,
    input  logic [REG_W-1:0] d0_rs,
    input  logic [REG_W-1:0] d0_rt,
    input  logic [REG_W-1:0] d0_dst,
    input  logic             d1_valid,
    input  logic [2:0]       d1_cls,
    input  logic [REG_W-1:0] d1_rs,
    input  logic [REG_W-1:0] d1_rt,
    input  logic             x0_valid,
    input  logic [2:0]       x0_cls,
    input  logic [REG_W-1:0] x0_dst,
    input  logic             x1_valid,
    input  logic [2:0]       x1_cls,
    input  logic [REG_W-1:0] x1_dst,
    input  logic             redirect_odd,
    input  logic             wb0_we,
    input  logic [REG_W-1:0] wb0_dst,
    input  logic             wb1_we,
    input  logic [REG_W-1:0] wb1_dst,
    output logic             dec_hold,
    output logic             ex_nop0,
    output logic             ex_nop1,
    output logic             wb0_we_ok
);
    logic [1:0]            eff;
    hazard_t               hz;
    issue_t                iss;
    logic [1:0][2:0]       dcls_a, xcls_a;
    logic [1:0][REG_W-1:0] dsa_a, dsb_a, xdst_a;

    assign dcls_a = {d1_cls, d0_cls};
    assign dsa_a  = {d1_rs, d0_rs};
    assign dsb_a  = {d1_rt, d0_rt};
    assign xcls_a = {x1_cls, x0_cls};
    assign xdst_a = {x1_dst, x0_dst};

    dih_detect #(.REG_W(REG_W)) u_detect (
        .eff      (eff),
        .dcls     (dcls_a),
        .dsa      (dsa_a),
        .dsb      (dsb_a),
        .even_dst (d0_dst),
        .xv       ({x1_valid, x0_valid}),
        .xcls     (xcls_a),
        .xdst     (xdst_a),
        .hz       (hz)
    );

    dih_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .dec_v        ({d1_valid, d0_valid}),
        .hz           (hz),
        .redirect_odd (redirect_odd),
        .eff          (eff),
        .iss          (iss)
    );

    dih_waw #(.REG_W(REG_W)) u_waw (
        .we0    (wb0_we),
        .dst0   (wb0_dst),
        .we1    (wb1_we),
        .dst1   (wb1_dst),
        .we0_ok (wb0_we_ok)
    );

    assign dec_hold = iss.hold;
    assign ex_nop0  = iss.nop0;
    assign ex_nop1  = iss.nop1;

    AST_EVEN_CTL_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (x0_valid && is_ctl(opcls_e'(x0_cls))) |-> (ex_nop0 && ex_nop1 && !dec_hold)); // R1

    AST_ODD_CTL_DROPS_ODD: assert property (@(posedge clk) disable iff (rst)
        (x1_valid && is_ctl(opcls_e'(x1_cls))) |-> ex_nop1); // R2

    AST_ONE_DATA_PORT: assert property (@(posedge clk) disable iff (rst)
        (is_mem(opcls_e'(d0_cls)) && is_mem(opcls_e'(d1_cls))) |-> (ex_nop0 || ex_nop1)); // R5

endmodule

// File: tb/sim_dual_issue_hazard.sv
module sim_dual_issue_hazard;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dv0, dv1, xv0, xv1, redir, we0, we1;
    logic [2:0] c0, c1, xc0, xc1;
    logic [4:0] a0, b0, w0, a1, b1, xw0, xw1, wd0, wd1;
    logic hold, n0, n1, we0_ok;
    int applied = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    dual_issue_hazard #(.REG_W(5)) u0 (
        .clk(clk), .rst(rst),
        .d0_valid(dv0), .d0_cls(c0), .d0_rs(a0), .d0_rt(b0), .d0_dst(w0),
        .d1_valid(dv1), .d1_cls(c1), .d1_rs(a1), .d1_rt(b1),
        .x0_valid(xv0), .x0_cls(xc0), .x0_dst(xw0),
        .x1_valid(xv1), .x1_cls(xc1), .x1_dst(xw1),
        .redirect_odd(redir),
        .wb0_we(we0), .wb0_dst(wd0), .wb1_we(we1), .wb1_dst(wd1),
        .dec_hold(hold), .ex_nop0(n0), .ex_nop1(n1), .wb0_we_ok(we0_ok)
    );

    function automatic logic rd(input logic [4:0] p, input logic [4:0] q, input logic [4:0] w);
        return (w != 5'd0) && (p == w || q == w);
    endfunction

    // expected {hold, nop0, nop1, eat0, eat1} from the requirement text
    function automatic logic [4:0] want(input logic m0, input logic m1);
        logic e0, e1, t0, t1, l0, l1, de, dodd, memc, intra;
        e0 = dv0 && !m0;
        e1 = dv1 && !m1;
        t0 = xv0 && (xc0 >= 3'd3) && (xc0 <= 3'd5);
        t1 = xv1 && (xc1 >= 3'd3) && (xc1 <= 3'd5);
        l0 = xv0 && (xc0 == 3'd1 || xc0 == 3'd5) && xw0 != 0;
        l1 = xv1 && (xc1 == 3'd1 || xc1 == 3'd5) && xw1 != 0;
        de   = e0 && ((l0 && rd(a0, b0, xw0)) || (l1 && rd(a0, b0, xw1)));
        dodd = e1 && ((l0 && rd(a1, b1, xw0)) || (l1 && rd(a1, b1, xw1)));
        memc = e0 && e1 && (c0 == 3'd1 || c0 == 3'd2) && (c1 == 3'd1 || c1 == 3'd2);
        intra = e0 && e1 && rd(a1, b1, w0);
        if (t0)                           return 5'b01100;
        if (t1 && de)                     return 5'b11101;
        if (t1)                           return {1'b0, !e0, 1'b1, 2'b00};
        if (de)                           return 5'b11100;
        if (dodd || memc || intra)        return {1'b1, !e0, 1'b1, e0, 1'b0};
        return {1'b0, !e0, !e1, 2'b00};
    endfunction

    function automatic string tag(input logic m0, input logic m1);
        logic [4:0] r;
        r = want(m0, m1);
        if (xv0 && xc0 >= 3'd3 && xc0 <= 3'd5) return "R1";
        if (xv1 && xc1 >= 3'd3 && xc1 <= 3'd5) return "R2";
        if (r[4] && r[3] && r[2]) return "R3";
        if (r[4] && (c0 == 3'd1 || c0 == 3'd2) && (c1 == 3'd1 || c1 == 3'd2)) return "R5";
        if (r[4] && rd(a1, b1, w0)) return "R6";
        if (r[4]) return "R4";
        return "R9";
    endfunction

    task automatic chk(input string t, input logic [2:0] got, input logic [2:0] exp);
        applied++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: {hold,nop0,nop1} got %b expected %b", t, got, exp);
        end
    endtask

    task automatic idle();
        dv0 = 0; dv1 = 0; xv0 = 0; xv1 = 0; redir = 0; we0 = 0; we1 = 0;
        c0 = 0; c1 = 0; xc0 = 0; xc1 = 0;
        a0 = 7; b0 = 9; w0 = 5; a1 = 7; b1 = 10; xw0 = 3; xw1 = 4; wd0 = 0; wd1 = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad++;
            $display("FAIL watchdog: cycles got %0d expected below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] ra, rb;
        int idx;
        idle();
        do_reset();
        #1 chk("R10 reset idle", {hold, n0, n1}, 3'b011);

        idx = 0;
        for (int e0c = 0; e0c < 6; e0c++)
        for (int e1c = 0; e1c < 6; e1c++)
        for (int k0 = 0; k0 < 7; k0++)
        for (int k1 = 0; k1 < 6; k1++)
        for (int s0 = 0; s0 < 3; s0++)
        for (int s1 = 0; s1 < 4; s1++) begin
            idle();
            xv0 = 1; xv1 = 1; xc0 = 3'(e0c); xc1 = 3'(e1c);
            xw0 = (idx % 2 == 0) ? 5'd3 : 5'd0;   // R9: zero destination never matches
            dv0 = (k0 != 6); c0 = (k0 == 6) ? 3'd0 : 3'(k0);
            dv1 = 1; c1 = 3'(k1);
            a0 = (s0 == 0) ? 5'd7 : (s0 == 1) ? xw0 : 5'd4;
            a1 = (s1 == 0) ? 5'd7 : (s1 == 1) ? xw0 : (s1 == 2) ? 5'd4 : 5'd5;
            idx++;
            @(negedge clk); rst = 0;
            #1;
            ra = want(1'b0, 1'b0);
            chk(tag(1'b0, 1'b0), {hold, n0, n1}, ra[4:2]);
            @(negedge clk);
            #1;
            rb = ra[4] ? want(ra[1], ra[0]) : want(1'b0, 1'b0);
            chk({tag(ra[1], ra[0]), " replay"}, {hold, n0, n1}, rb[4:2]);
            rst = 1;
        end
        @(negedge clk); rst = 0;

        // R6 split, R4 replay, then R10 reset clears the live mask
        idle(); do_reset();
        dv0 = 1; dv1 = 1; a1 = 5;
        #1 chk("R6 pair dependency split", {hold, n0, n1}, 3'b101);
        @(negedge clk); #1 chk("R4 replay after split", {hold, n0, n1}, 3'b010);
        a1 = 7;
        @(negedge clk); #1 chk("R4 pair released", {hold, n0, n1}, 3'b000);
        a1 = 5;
        @(negedge clk); #1;
        rst = 1; a1 = 7;
        @(negedge clk); rst = 0; #1;
        chk("R10 reset clears replay mask", {hold, n0, n1}, 3'b000);

        // R7 odd target with immediate advance
        idle(); do_reset();
        dv0 = 1; dv1 = 1; redir = 1;
        #1 chk("R7 redirect cycle", {hold, n0, n1}, 3'b000);
        @(negedge clk); redir = 0;
        #1 chk("R7 even squashed after odd target", {hold, n0, n1}, 3'b010);
        @(negedge clk); #1 chk("R7 squash lasts one pair", {hold, n0, n1}, 3'b000);

        // R2 with even stall, R7 squash waits for the new pair
        idle(); do_reset();
        dv0 = 1; dv1 = 1; xv0 = 1; xc0 = 3'd1; xv1 = 1; xc1 = 3'd3; a0 = 3; redir = 1;
        #1 chk("R2 odd transfer with even stall", {hold, n0, n1}, 3'b111);
        @(negedge clk); redir = 0; xv0 = 0; xv1 = 0;
        #1 chk("R2 odd stays dead on replay", {hold, n0, n1}, 3'b001);
        @(negedge clk); #1 chk("R7 deferred squash on new pair", {hold, n0, n1}, 3'b010);

        // R8 writeback arbitration
        idle();
        we0 = 1; we1 = 1; wd0 = 12; wd1 = 12;
        #1 chk("R8 same destination", {2'b00, we0_ok}, 3'b000);
        wd1 = 13;
        #1 chk("R8 different destination", {2'b00, we0_ok}, 3'b001);
        wd1 = 12; we1 = 0;
        #1 chk("R8 odd not writing", {2'b00, we0_ok}, 3'b001);

        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule